// File: doc/BRIEF.md
# Modem Clock Configuration and Divider

This block sits at the clock root of a low-power FSK modem. Three static strap inputs pick where the raw clock comes from. The choices are a crystal oscillator, an external CMOS clock, or an on-die RC oscillator. The same straps decide whether a buffered clock is driven out, and at what ratio. The block runs on the raw source clock. It produces a core clock enable at the modem rate of 1.2288 MHz. A 3.6864 MHz source is divided by three to reach that rate, and a 1.2288 MHz source is used as it is. It also drives an optional output clock at divide-by-1, divide-by-2 or divide-by-3 of the source.

A high level on the synchronous power-down input stops everything. The core enable, the output clock and both oscillator run requests go low. While power-down is held, the straps are sampled on every clock. The last sampled value stays in force from the release of power-down until the next power-down. Cycle numbering below counts from the first rising edge with `rst` low, which is cycle 0.

Top module: `modem_clk_cfg`

## Requirements
- R1: While `rst` is high, one clock after it is first seen, `core_en`, `clk_out`, `xo_run` and `rc_run` are all low.
- R2: The straps sampled at the last rising edge with `rst` high set the configuration. Later strap changes have no effect on any output until the next power-down.
- R3: With `strap_ext`=0, `xo_run`=1 and `rc_run`=0. With `strap_ext`=1 and `strap_sel[1]`=1, `rc_run`=1 and `xo_run`=0. With `strap_ext`=1 and `strap_sel[1]`=0, both are 0.
- R4: For {`strap_ext`,`strap_sel`} = 0xx or 100, `core_en` is high in cycles 0, 3, 6 and so on, and low in all other cycles.
- R5: For {`strap_ext`,`strap_sel`} = 101, 110 or 111, `core_en` is high in every cycle from cycle 0.
- R6: For {`strap_ext`,`strap_sel`} = 000, 100, 101 or 110, `clk_out` stays low.
- R7: For 001 and 111, `clk_out` follows the source clock. It is high in every clock-high phase from cycle 1 and low in every clock-low phase.
- R8: For 010, `clk_out` is a divide-by-2 clock. It is high through all of cycles 1, 3, 5 and so on, and low through the even cycles.
- R9: For 011, `clk_out` is a divide-by-3 clock with 50% duty. From cycle 3 it is high for the whole of cycle 3k and for the high phase of cycle 3k+1. It is low otherwise, and low throughout cycles 0 to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Raw source clock (crystal, external CMOS or RC) |
| rst | input | 1 | Synchronous power-down request, active high |
| strap_ext | input | 1 | 0: crystal source; 1: external CMOS clock or RC oscillator |
| strap_sel | input | 2 | Configuration code, decoded together with `strap_ext` |
| core_en | output | 1 | One-source-cycle enable at the 1.2288 MHz core rate |
| clk_out | output | 1 | Buffered clock output, held low when not selected |
| xo_run | output | 1 | Run request to the crystal oscillator |
| rc_run | output | 1 | Run request to the internal RC oscillator |

## Verification
The bench sweeps all eight strap codes. For each code it samples both clock phases over nine cycles after release and compares against patterns computed from the cycle number. The half-cycle extension of the divide-by-3 output is checked by low-phase samples. A design with the falling-edge stage on the wrong edge, or missing, shows a 33% or 67% duty. The first active cycles are checked exactly, so a counter that starts one cycle late misplaces `core_en` and the first output edges. Every run also inverts the straps mid-stream, which exposes any strap path that is not frozen at release. Power-down entered from every mode must clear all outputs, including a divide-by-1 output whose gate sits on the falling edge.

// File: rtl/modem_clk_pkg.sv
package modem_clk_pkg;

    typedef enum logic [1:0] {
        SRC_XO  = 2'd0,
        SRC_EXT = 2'd1,
        SRC_RC  = 2'd2
    } src_e;

    typedef enum logic [1:0] {
        OUT_NONE = 2'd0,
        OUT_DIV1 = 2'd1,
        OUT_DIV2 = 2'd2,
        OUT_DIVN = 2'd3
    } out_e;

    typedef struct packed {
        src_e src;       // which oscillator feeds clk
        logic core_div;  // 1: source is fast, divide for the core rate
        out_e out_mode;  // buffered output ratio
    } clk_cfg_t;

    // Strap table: source type and output ratio decoded together.
    function automatic clk_cfg_t decode_straps(input logic ext, input logic [1:0] sel);
        clk_cfg_t c;
        if (!ext) begin
            c.src      = SRC_XO;
            c.core_div = 1'b1;
            c.out_mode = out_e'(sel);
        end else begin
            c.src      = sel[1] ? SRC_RC : SRC_EXT;
            c.core_div = (sel == 2'b00);
            c.out_mode = (sel == 2'b11) ? OUT_DIV1 : OUT_NONE;
        end
        return c;
    endfunction

endpackage

// File: rtl/modem_clk_strap.sv
module modem_clk_strap
    import modem_clk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       strap_ext,
    input  logic [1:0] strap_sel,
    output clk_cfg_t   cfg,
    output logic       run
);
    clk_cfg_t cfg_q;
    logic     run_q;

    // Straps track while held in power-down, freeze on release.
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= decode_straps(strap_ext, strap_sel);
            run_q <= 1'b0;
        end else begin
            run_q <= 1'b1;
        end
    end

    assign cfg = cfg_q;
    assign run = run_q;
endmodule

// File: rtl/modem_clk_tick.sv
module modem_clk_tick #(
    parameter int DIV_N = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic div_en,
    output logic core_en,
    output logic wrap
);
    localparam int CW = (DIV_N > 2) ? $clog2(DIV_N) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_N - 1);

    logic [CW-1:0] cnt_q;

    assign wrap = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (run && div_en) begin
            cnt_q <= wrap ? '0 : cnt_q + CW'(1);
        end
    end

    assign core_en = run && (!div_en || cnt_q == '0);
endmodule

// File: rtl/modem_clk_outgen.sv
module modem_clk_outgen
    import modem_clk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  out_e mode,
    input  logic wrap,
    output logic clk_out
);
    logic tog_q;   // divide-by-2 toggle
    logic pos_q;   // divide-by-N pulse, rising-edge stage
    logic neg_q;   // same pulse delayed half a cycle
    logic gate_q;  // divide-by-1 gate, changes only while clk is low

    always_ff @(posedge clk) begin
        if (rst) begin
            tog_q <= 1'b0;
            pos_q <= 1'b0;
        end else begin
            if (run && mode == OUT_DIV2) begin
                tog_q <= ~tog_q;
            end
            pos_q <= run && (mode == OUT_DIVN) && wrap;
        end
    end

    always_ff @(negedge clk) begin
        if (rst) begin
            gate_q <= 1'b0;
            neg_q  <= 1'b0;
        end else begin
            gate_q <= run && (mode == OUT_DIV1);
            neg_q  <= pos_q;
        end
    end

    always_comb begin
        unique case (mode)
            OUT_DIV1: clk_out = clk & gate_q;
            OUT_DIV2: clk_out = tog_q;
            OUT_DIVN: clk_out = pos_q | neg_q;
            default:  clk_out = 1'b0;
        endcase
    end
endmodule

// File: rtl/modem_clk_cfg.sv
module modem_clk_cfg
    import modem_clk_pkg::*;
#(
    parameter int DIV_N = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       strap_ext,
    input  logic [1:0] strap_sel,
    output logic       core_en,
    output logic       clk_out,
    output logic       xo_run,
    output logic       rc_run
);
    clk_cfg_t cfg_q;
    logic     run_q;
    logic     wrap;

    modem_clk_strap u_strap (
        .clk       (clk),
        .rst       (rst),
        .strap_ext (strap_ext),
        .strap_sel (strap_sel),
        .cfg       (cfg_q),
        .run       (run_q)
    );

    modem_clk_tick #(.DIV_N(DIV_N)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .run     (run_q),
        .div_en  (cfg_q.core_div),
        .core_en (core_en),
        .wrap    (wrap)
    );

    modem_clk_outgen u_out (
        .clk     (clk),
        .rst     (rst),
        .run     (run_q),
        .mode    (cfg_q.out_mode),
        .wrap    (wrap),
        .clk_out (clk_out)
    );

    assign xo_run = run_q && (cfg_q.src == SRC_XO);
    assign rc_run = run_q && (cfg_q.src == SRC_RC);
endmodule

// File: rtl/modem_clk_cfg_chk.sv
module modem_clk_cfg_chk
    import modem_clk_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     core_en,
    input logic     clk_out,
    input logic     xo_run,
    input logic     rc_run,
    input clk_cfg_t cfg
);
    logic rst_seen;

    always_ff @(posedge clk) rst_seen <= rst;

    // R1
    always @(negedge clk) begin
        if (rst_seen) begin
            rst_quiet_chk: assert (!core_en && !xo_run && !rc_run);
        end
    end

    // R3
    src_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({xo_run, rc_run}));

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(cfg));

    // R4
    core_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (core_en && cfg.core_div) |=> !core_en);

    // R5
    core_full_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg.core_div && $past(!rst)) |-> core_en);

    // R6
    quiet_out_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.out_mode == OUT_NONE) |-> !clk_out);

    // R8
    div2_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.out_mode == OUT_DIV2 && $past(!rst, 2)) |-> (clk_out != $past(clk_out)));
endmodule

bind modem_clk_cfg modem_clk_cfg_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .core_en (core_en),
    .clk_out (clk_out),
    .xo_run  (xo_run),
    .rc_run  (rc_run),
    .cfg     (cfg_q)
);

// File: tb/tb_modem_clk_cfg.sv
module tb_modem_clk_cfg;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       strap_ext = 1'b0;
    logic [1:0] strap_sel = 2'b00;
    logic       core_en, clk_out, xo_run, rc_run;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    modem_clk_cfg dut (
        .clk       (clk),
        .rst       (rst),
        .strap_ext (strap_ext),
        .strap_sel (strap_sel),
        .core_en   (core_en),
        .clk_out   (clk_out),
        .xo_run    (xo_run),
        .rc_run    (rc_run)
    );

    always #10 clk = ~clk;  // 50 MHz

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // mode: 0 none, 1 div1, 2 div2, 3 div3
    function automatic int out_mode(input logic e, input logic [1:0] s);
        if (!e) return int'(s);
        return (s == 2'b11) ? 1 : 0;
    endfunction

    function automatic string mreq(input int m);
        case (m)
            1: return "R7";
            2: return "R8";
            3: return "R9";
            default: return "R6";
        endcase
    endfunction

    task automatic run_cfg(input logic e, input logic [1:0] s);
        int  m    = out_mode(e, s);
        bit  div  = !e || (s == 2'b00);
        logic exp_h, exp_l, exp_c;
        rst       = 1'b1;
        strap_ext = e;
        strap_sel = s;
        repeat (3) @(posedge clk);
        #5;
        // R1 power-down quiet, high phase
        chk("R1", "core_en", core_en, 1'b0);
        chk("R1", "clk_out_hi", clk_out, 1'b0);
        chk("R1", "xo_run", xo_run, 1'b0);
        chk("R1", "rc_run", rc_run, 1'b0);
        #10;
        chk("R1", "clk_out_lo", clk_out, 1'b0);
        @(posedge clk);
        #5 rst = 1'b0;
        for (int k = 0; k < 9; k++) begin
            @(posedge clk);
            #5;
            exp_c = div ? (k % 3 == 0) : 1'b1;
            chk(div ? "R4" : "R5", "core_en", core_en, exp_c);
            case (m)
                1: begin exp_h = (k >= 1);                         exp_l = 1'b0;   end
                2: begin exp_h = (k % 2 == 1);                     exp_l = exp_h;  end
                3: begin exp_h = (k >= 3) && (k % 3 != 2);         exp_l = (k >= 3) && (k % 3 == 0); end
                default: begin exp_h = 1'b0;                       exp_l = 1'b0;   end
            endcase
            chk(mreq(m), "clk_out_hi", clk_out, exp_h);
            // R3 oscillator run requests
            chk("R3", "xo_run", xo_run, !e);
            chk("R3", "rc_run", rc_run, e & s[1]);
            if (k == 2) begin
                // R2: strap changes after release must be ignored
                strap_ext = ~e;
                strap_sel = ~s;
            end
            #10;
            chk(mreq(m), "clk_out_lo", clk_out, exp_l);
        end
        // R2 a flipped strap left no trace by the end of the run
        chk("R2", "xo_run_after_flip", xo_run, !e);
    endtask

    initial begin
        for (int c = 0; c < 8; c++) begin
            run_cfg(c[2], c[1:0]);
        end
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #5;
        chk("R1", "core_en_final", core_en, 1'b0);
        chk("R1", "clk_out_final", clk_out, 1'b0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule